// File: doc/BRIEF.md
# Flash Byte-Program Command Sequencer

This block sits between a host bus and a nonvolatile cell array and takes care of byte programming for the host. The host talks to it through active-low chip enable, write enable and output enable strobes, which are sampled on the block clock. Two host writes start an operation. The first is a set-up code. The second carries the target address and the byte to store. From that point the block runs the whole operation by itself. It drives a timed program pulse to the array and then a one-cycle verify strobe, and it repeats this pair until the cell matches or an attempt limit is used up.

While the operation runs, host reads return a status byte instead of array contents. The host learns progress by polling that byte. When the byte verifies, the block goes back to plain array reads. When the attempt limit is reached, the block holds a failure status until the host writes the reset code twice in a row.

Top module: `fbp_sequencer`

## Requirements
- R1: Writing the set-up code 0x40 and then one more write starts a program operation on the address and data of that second write. The array pulse strobe carries the captured address on `arr_addr` and the captured byte on `arr_wdata`.
- R2: In array-read mode, any write whose data is not 0x40 is ignored. The array is not pulsed and later reads still return the array contents.
- R3: The address of a write is taken at the moment the later of chip enable and write enable goes low. Address changes after that moment have no effect.
- R4: The data of a write is taken at the moment the earlier of chip enable and write enable goes high. Data changes after that moment have no effect.
- R5: Every program pulse keeps `arr_pulse` high for exactly PULSE_W clock cycles (default 8). It is followed at once by a single-cycle `arr_verify` strobe, and the two strobes are never high together.
- R6: Verify looks only at bits that are 0 in the target byte, which means bits that have to go from 1 to 0. When all of them read 0, the operation ends and host reads return array data again, even if other bits differ from the target.
- R7: When MAX_PULSES pulses (default 25) have been given without a match, no further pulse is issued. Status bit 5 then reads 1.
- R8: While an operation runs or has failed, status bit 7 reads as the inverse of bit 7 of the target byte. Once the operation completes, a read at the target address returns the true stored byte.
- R9: While an operation runs, status bit 6 inverts at the end of each host read. In the failed state it holds its value from one read to the next.
- R10: The failed state is left only after two writes of 0xFF in a row. A single 0xFF followed by any other value keeps the failure status.
- R11: Host writes made during a running operation are ignored. They neither start a new operation nor pulse any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | AW | Host address |
| din | input | DW | Host write data |
| dout | output | DW | Host read data: array byte or status byte |
| dout_en | output | 1 | High while a host read is active |
| arr_addr | output | AW | Array address: the target during an operation, else the host address |
| arr_wdata | output | DW | Target byte presented to the array |
| arr_pulse | output | 1 | Program pulse strobe |
| arr_verify | output | 1 | Verify read strobe |
| arr_rdata | input | DW | Array read data for `arr_addr` |

## Verification
The hardest state to reach from the ports is the failed state. Getting there needs a cell that never verifies and an operation that uses up every attempt. The bench array model lets the bench choose how many pulses a cell needs before its bits clear. Setting that count far above the limit keeps the cell unprogrammed, and the bench then waits out all 25 pulses before it polls status and walks through the double 0xFF exit. The same knob, together with a cell preloaded by an earlier operation, produces a verify that matches while unmasked bits still differ from the target.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [2:0] {
      M_READ,
      M_SETUP,
      M_BUSY,
      M_FAIL,
      M_FAIL_RST
   } mode_e;

   typedef enum logic [1:0] {
      E_IDLE,
      E_PULSE,
      E_VERIFY
   } eng_e;

   localparam logic [7:0] CMD_SETUP = 8'h40;
   localparam logic [7:0] CMD_RESET = 8'hFF;

   localparam int POLL_BIT   = 7;
   localparam int TOGGLE_BIT = 6;
   localparam int FAIL_BIT   = 5;

endpackage

// File: rtl/fbp_bus_capture.sv
module fbp_bus_capture #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          wr_evt,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          rd_end
);

   logic wr_act, wr_q, rd_act, rd_q;

   assign wr_act = !ce_n && !we_n;
   assign rd_act = !ce_n && !oe_n;
   assign rd_end = rd_q && !rd_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         wr_evt  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_q   <= wr_act;
         rd_q   <= rd_act;
         wr_evt <= wr_q && !wr_act;
         // later of the two strobes falling
         if (wr_act && !wr_q) wr_addr <= addr;
         // earlier of the two strobes rising
         if (!wr_act && wr_q) wr_data <= din;
      end
   end

endmodule

// File: rtl/fbp_prog_engine.sv
module fbp_prog_engine
   import fbp_pkg::*;
#(
   parameter int DW         = 8,
   parameter int PULSE_W    = 8,
   parameter int MAX_PULSES = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] tgt,
   input  logic [DW-1:0] arr_rdata,
   output logic          pulse,
   output logic          verify,
   output logic          done,
   output logic          fail
);

   localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
   localparam int NW = $clog2(MAX_PULSES + 1);

   eng_e          st;
   logic [CW-1:0] tcnt;
   logic [NW-1:0] ncnt;
   logic          match;

   assign match  = ((arr_rdata & ~tgt) == '0);
   assign pulse  = (st == E_PULSE);
   assign verify = (st == E_VERIFY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= E_IDLE;
         tcnt <= '0;
         ncnt <= '0;
         done <= 1'b0;
         fail <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         unique case (st)
            E_IDLE: begin
               if (start) begin
                  st   <= E_PULSE;
                  tcnt <= '0;
                  ncnt <= NW'(1);
               end
            end
            E_PULSE: begin
               if (tcnt == CW'(PULSE_W - 1)) st <= E_VERIFY;
               else tcnt <= tcnt + 1'b1;
            end
            E_VERIFY: begin
               if (match) begin
                  done <= 1'b1;
                  st   <= E_IDLE;
               end else if (ncnt == NW'(MAX_PULSES)) begin
                  fail <= 1'b1;
                  st   <= E_IDLE;
               end else begin
                  ncnt <= ncnt + 1'b1;
                  tcnt <= '0;
                  st   <= E_PULSE;
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fbp_sequencer.sv
module fbp_sequencer
   import fbp_pkg::*;
#(
   parameter int AW         = 8,
   parameter int DW         = 8,
   parameter int PULSE_W    = 8,
   parameter int MAX_PULSES = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dout_en,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] arr_wdata,
   output logic          arr_pulse,
   output logic          arr_verify,
   input  logic [DW-1:0] arr_rdata
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("fbp_sequencer: DW must be at least 8");
      end
      if (AW < 1) begin : g_bad_aw
         $error("fbp_sequencer: AW must be at least 1");
      end
      if (PULSE_W < 1) begin : g_bad_pw
         $error("fbp_sequencer: PULSE_W must be at least 1");
      end
      if (MAX_PULSES < 1) begin : g_bad_mp
         $error("fbp_sequencer: MAX_PULSES must be at least 1");
      end
   endgenerate

   logic          wr_evt, rd_end;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          eng_done, eng_fail, start_q;
   mode_e         mode;
   logic [AW-1:0] tgt_addr;
   logic [DW-1:0] tgt_data;
   logic          tgl_q;
   logic          busy, failed;
   logic [DW-1:0] stat;

   fbp_bus_capture #(.AW(AW), .DW(DW)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .we_n    (we_n),
      .oe_n    (oe_n),
      .addr    (addr),
      .din     (din),
      .wr_evt  (wr_evt),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_end  (rd_end)
   );

   fbp_prog_engine #(.DW(DW), .PULSE_W(PULSE_W), .MAX_PULSES(MAX_PULSES)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_q),
      .tgt       (tgt_data),
      .arr_rdata (arr_rdata),
      .pulse     (arr_pulse),
      .verify    (arr_verify),
      .done      (eng_done),
      .fail      (eng_fail)
   );

   assign busy   = (mode == M_BUSY);
   assign failed = (mode == M_FAIL) || (mode == M_FAIL_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= M_READ;
         tgt_addr <= '0;
         tgt_data <= '0;
         start_q  <= 1'b0;
         tgl_q    <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (busy && rd_end) tgl_q <= ~tgl_q;
         unique case (mode)
            M_READ: if (wr_evt && wr_data[7:0] == CMD_SETUP) mode <= M_SETUP;
            M_SETUP: begin
               if (wr_evt) begin
                  tgt_addr <= wr_addr;
                  tgt_data <= wr_data;
                  start_q  <= 1'b1;
                  mode     <= M_BUSY;
               end
            end
            M_BUSY: begin
               if (eng_done)      mode <= M_READ;
               else if (eng_fail) mode <= M_FAIL;
            end
            M_FAIL: if (wr_evt && wr_data[7:0] == CMD_RESET) mode <= M_FAIL_RST;
            M_FAIL_RST: begin
               if (wr_evt) mode <= (wr_data[7:0] == CMD_RESET) ? M_READ : M_FAIL;
            end
            default: mode <= M_READ;
         endcase
      end
   end

   always_comb begin
      stat             = '0;
      stat[POLL_BIT]   = ~tgt_data[POLL_BIT];
      stat[TOGGLE_BIT] = tgl_q;
      stat[FAIL_BIT]   = failed;
   end

   assign dout      = (mode == M_READ || mode == M_SETUP) ? arr_rdata : stat;
   assign dout_en   = !ce_n && !oe_n;
   assign arr_addr  = busy ? tgt_addr : addr;
   assign arr_wdata = tgt_data;

endmodule

// File: rtl/fbp_sequencer_chk.sv
module fbp_sequencer_chk #(
   parameter int PULSE_W    = 8,
   parameter int MAX_PULSES = 25
) (
   input logic clk,
   input logic rst_n,
   input logic arr_pulse,
   input logic arr_verify,
   input logic busy,
   input logic failed,
   input logic tgl
);

   int plen;
   int vcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plen <= 0;
         vcnt <= 0;
      end else begin
         plen <= arr_pulse ? plen + 1 : 0;
         if (!busy)          vcnt <= 0;
         else if (arr_verify) vcnt <= vcnt + 1;
      end
   end

   // R5
   verify_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_verify |-> $past(arr_pulse));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_pulse && arr_verify));

   // R5
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plen <= PULSE_W);

   // R7
   attempt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vcnt <= MAX_PULSES);

   // R7
   no_pulse_failed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      failed |-> !arr_pulse);

   // R9
   toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tgl));

endmodule

bind fbp_sequencer fbp_sequencer_chk #(.PULSE_W(PULSE_W), .MAX_PULSES(MAX_PULSES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arr_pulse  (arr_pulse),
   .arr_verify (arr_verify),
   .busy       (busy),
   .failed     (failed),
   .tgl        (tgl_q)
);

// File: tb/fbp_sequencer_test.sv
`timescale 1ns/1ps
module fbp_sequencer_test;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int PW = 8;
   localparam int MP = 25;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata;
   logic          arr_pulse, arr_verify;
   logic [DW-1:0] arr_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [7:0] mem [0:255];
   int  need_at = 0;
   int  ptotal = 0;
   int  vtotal = 0;
   int  plen = 0;
   int  last_plen = 0;
   logic pprev = 1'b0;

   always #2.5 clk = ~clk;

   fbp_sequencer #(.AW(AW), .DW(DW), .PULSE_W(PW), .MAX_PULSES(MP)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_pulse(arr_pulse),
      .arr_verify(arr_verify), .arr_rdata(arr_rdata)
   );

   // cell array model: a cell takes the written byte after a chosen pulse count
   assign arr_rdata = mem[arr_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
      end else begin
         if (arr_pulse) plen <= plen + 1;
         else if (plen != 0) begin
            last_plen <= plen;
            plen <= 0;
         end
         if (arr_verify) vtotal <= vtotal + 1;
         if (arr_pulse && !pprev) begin
            ptotal <= ptotal + 1;
            if (ptotal + 1 >= need_at) mem[arr_addr] <= mem[arr_addr] & arr_wdata;
         end
      end
      pprev <= arr_pulse;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
      cycles(2);
      ce_n = 1'b1; we_n = 1'b1;
      cycles(2);
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      cycles(2);
      d = dout;
      ce_n = 1'b1; oe_n = 1'b1;
      cycles(2);
   endtask

   task automatic test_reset();
      logic [7:0] d;
      bus_read(8'h10, d);
      check("R2 reset read returns array", d, 8'hFF);
      check("R5 no pulse after reset", ptotal, 0);
   endtask

   task automatic test_ignored();
      logic [7:0] d;
      int p0 = ptotal;
      bus_write(8'h10, 8'h55);
      bus_write(8'h10, 8'h00);
      cycles(30);
      bus_read(8'h10, d);
      check("R2 stray writes leave array", d, 8'hFF);
      check("R2 stray writes give no pulse", ptotal - p0, 0);
   endtask

   task automatic test_program();
      logic [7:0] r1, r2, d;
      int p0 = ptotal;
      int v0 = vtotal;
      need_at = ptotal + 3;
      bus_write(8'h00, 8'h40);
      bus_write(8'h20, 8'h5A);
      bus_read(8'h20, r1);
      bus_read(8'h20, r2);
      check("R8 poll bit while busy", r1[7], 1);
      check("R9 toggle flips between reads", r1[6] ^ r2[6], 1);
      check("R7 fail bit clear while busy", r1[5], 0);
      cycles(60);
      bus_read(8'h20, d);
      check("R1 R8 stored byte after completion", d, 8'h5A);
      check("R5 pulse count", ptotal - p0, 3);
      check("R5 verify per pulse", vtotal - v0, 3);
      check("R5 pulse width", last_plen, PW);
   endtask

   task automatic test_edges();
      logic [7:0] d;
      need_at = ptotal + 1;
      bus_write(8'h30, 8'h40);
      @(negedge clk);
      addr = 8'h33; din = 8'h77; ce_n = 1'b0;
      cycles(2);
      addr = 8'h31; we_n = 1'b0;
      cycles(2);
      addr = 8'h37; din = 8'h0F;
      cycles(2);
      ce_n = 1'b1;
      cycles(2);
      din = 8'hAA;
      cycles(2);
      we_n = 1'b1;
      cycles(40);
      bus_read(8'h31, d);
      check("R3 R4 target from strobe edges", d, 8'h0F);
      bus_read(8'h33, d);
      check("R3 early address not used", d, 8'hFF);
      bus_read(8'h37, d);
      check("R3 late address not used", d, 8'hFF);
   endtask

   task automatic test_masked();
      logic [7:0] d;
      int p0;
      need_at = ptotal + 1;
      bus_write(8'h00, 8'h40);
      bus_write(8'h40, 8'h0F);
      cycles(40);
      p0 = ptotal;
      need_at = ptotal + 2;
      bus_write(8'h00, 8'h40);
      bus_write(8'h40, 8'h3C);
      cycles(60);
      bus_read(8'h40, d);
      check("R6 masked verify ends op", d, 8'h0C);
      check("R6 pulses until masked match", ptotal - p0, 2);
   endtask

   task automatic test_busy_writes();
      logic [7:0] d;
      need_at = ptotal + 4;
      bus_write(8'h00, 8'h40);
      bus_write(8'h50, 8'h00);
      bus_write(8'h60, 8'h40);
      bus_write(8'h60, 8'h00);
      cycles(80);
      bus_read(8'h60, d);
      check("R11 write during busy ignored", d, 8'hFF);
      bus_read(8'h50, d);
      check("R11 running op completes", d, 8'h00);
   endtask

   task automatic test_fail();
      logic [7:0] r1, r2, d;
      int p0 = ptotal;
      need_at = ptotal + 100000;
      bus_write(8'h00, 8'h40);
      bus_write(8'h70, 8'h12);
      cycles(MP * (PW + 1) + 40);
      check("R7 pulse limit", ptotal - p0, MP);
      bus_read(8'h70, r1);
      bus_read(8'h70, r2);
      check("R7 fail bit set", r1[5], 1);
      check("R8 poll bit after failure", r1[7], 1);
      check("R9 toggle stable when failed", r1[6] ^ r2[6], 0);
      bus_write(8'h00, 8'hFF);
      bus_read(8'h20, d);
      check("R10 single reset keeps failure", d[5], 1);
      bus_write(8'h00, 8'h00);
      bus_write(8'h00, 8'hFF);
      bus_read(8'h20, d);
      check("R10 broken pair keeps failure", d[5] & ~d[3], 1);
      bus_write(8'h00, 8'hFF);
      bus_read(8'h20, d);
      check("R10 double reset returns to array", d, 8'h5A);
      check("R7 no pulse after failure", ptotal - p0, MP);
   endtask

   initial begin
      cycles(4);
      rst_n = 1'b1;
      cycles(2);
      test_reset();
      test_ignored();
      test_program();
      test_edges();
      test_masked();
      test_busy_writes();
      test_fail();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule